// File: doc/BRIEF.md
# Remappable Interconnect Address Decoder

This block is the address decoder shared by every master port of a small multi-master interconnect. Each master presents a request valid and a 32-bit address. The block answers with a one-hot slave select for that master, or with a decode error when no slave is visible at that address. There are five slaves: boot ROM, on-chip RAM, SDRAM, a main bridge window and a lightweight bridge window.

A single remap register sets the map that all masters share. Its low bits choose which memory answers in the 64 KB low window at address zero. Remap bits may be set together. When more than one bit claims the low window, the set bit of lowest order wins. Two further bits open or close the two bridge windows. Any of three masters may write the register. When writes collide in one cycle, the master with the lowest index wins.

The select and error outputs are registered for timing, so each request is answered one clock after it is presented.

Top module: `remap_addr_decoder`

## Requirements
- R1: After reset the remap register reads 0x00, and every select and decode-error output is low.
- R2: Slave select bit positions are: 0 boot ROM, 1 on-chip RAM, 2 SDRAM, 3 main bridge, 4 lightweight bridge. With remap bit 0 set, addresses 0x0000_0000 to 0x0000_FFFF select on-chip RAM.
- R3: With remap bit 1 set and bit 0 clear, the low window selects SDRAM. With both bits set, on-chip RAM wins.
- R4: With remap bits 0 and 1 both clear, the low window selects boot ROM.
- R5: Whatever the remap value, on-chip RAM answers at 0xFFFF_0000 to 0xFFFF_FFFF, and SDRAM answers at 0x0001_0000 to 0xBFFF_FFFF.
- R6: Addresses 0xC000_0000 to 0xFBFF_FFFF select the main bridge when remap bit 4 is set. When bit 4 is clear, they raise the decode error.
- R7: Addresses 0xFF20_0000 to 0xFF3F_FFFF select the lightweight bridge when remap bit 3 is set. When bit 3 is clear, they raise the decode error.
- R8: Every other address (0xFC00_0000 to 0xFF1F_FFFF and 0xFF40_0000 to 0xFFFE_FFFF) raises the decode error and selects no slave.
- R9: One remap register governs the map of all masters at once.
- R10: A remap write changes decoding for requests presented in the cycle after the write. A request presented in the same cycle as the write is decoded with the old value.
- R11: When several masters write the remap register in the same cycle, the value from the lowest-indexed writer is stored.
- R12: Select and error outputs appear one clock after the request. A master whose request valid is low gets all selects and its error low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rmp_wr_en | input | 3 | Per-master remap write strobe |
| rmp_wr_data | input | 15 | Per-master remap write value, 5 bits each, master 0 in the low bits |
| req_valid | input | 3 | Per-master request valid |
| req_addr | input | 96 | Per-master address, 32 bits each, master 0 in the low bits |
| slv_sel | output | 15 | Registered one-hot select, 5 bits per master |
| dec_err | output | 3 | Registered decode error per master |
| remap_val | output | 5 | Current remap register value |

## Verification
The assertions assume that the write strobes and request valids are known, never X, whenever reset is released. They also assume that the address of a valid request is stable across its sampling edge. The stimulus changes every input only on the falling clock edge and returns strobes and valids to zero between scenarios. Every remap value the bench writes keeps to the five defined bits.

// File: rtl/remap_pkg.sv
package remap_pkg;
  localparam int ADDR_W  = 32;
  localparam int REMAP_W = 5;
  localparam int NSLV    = 5;

  // slave select bit positions
  localparam int SLV_BOOT  = 0;
  localparam int SLV_OCRAM = 1;
  localparam int SLV_SDRAM = 2;
  localparam int SLV_MAINB = 3;
  localparam int SLV_LWB   = 4;

  // remap register bit positions (lower index = higher priority for low window)
  localparam int RMP_OCRAM = 0;
  localparam int RMP_SDRAM = 1;
  localparam int RMP_LWB   = 3;
  localparam int RMP_MAINB = 4;

  typedef struct packed {
    logic [ADDR_W-1:0] lo;
    logic [ADDR_W-1:0] hi;
  } win_t;

  localparam win_t WIN_LOW    = '{lo: 32'h0000_0000, hi: 32'h0000_FFFF};
  localparam win_t WIN_SDRAM  = '{lo: 32'h0001_0000, hi: 32'hBFFF_FFFF};
  localparam win_t WIN_MAINB  = '{lo: 32'hC000_0000, hi: 32'hFBFF_FFFF};
  localparam win_t WIN_LWB    = '{lo: 32'hFF20_0000, hi: 32'hFF3F_FFFF};
  localparam win_t WIN_OCR_HI = '{lo: 32'hFFFF_0000, hi: 32'hFFFF_FFFF};

  function automatic logic in_win(input logic [ADDR_W-1:0] a, input win_t w);
    return (a >= w.lo) && (a <= w.hi);
  endfunction
endpackage

// File: rtl/remap_reg.sv
module remap_reg
  import remap_pkg::*;
#(
  parameter int NUM_MST = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_MST-1:0]         wr_en,
  input  logic [NUM_MST*REMAP_W-1:0] wr_data,
  output logic [REMAP_W-1:0]         remap_q
);
  logic [REMAP_W-1:0] remap_d;
  logic               any_wr;

  assign any_wr = |wr_en;

  // next state: scan high to low so the lowest-indexed writer overrides
  always_comb begin
    remap_d = remap_q;
    for (int i = NUM_MST - 1; i >= 0; i--) begin
      if (wr_en[i]) remap_d = wr_data[i*REMAP_W +: REMAP_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      remap_q <= '0;
    else if (any_wr) remap_q <= remap_d;
  end

  // R11
  mst0_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en[0] |=> remap_q == $past(wr_data[REMAP_W-1:0]));

  // R10
  hold_no_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !any_wr |=> $stable(remap_q));
endmodule

// File: rtl/remap_window_dec.sv
module remap_window_dec
  import remap_pkg::*;
(
  input  logic [ADDR_W-1:0]  addr,
  input  logic [REMAP_W-1:0] remap,
  output logic [NSLV-1:0]    sel,
  output logic               derr
);
  logic hit_low, hit_sdram, hit_mainb, hit_lwb, hit_ocr;

  assign hit_low   = in_win(addr, WIN_LOW);
  assign hit_sdram = in_win(addr, WIN_SDRAM);
  assign hit_mainb = in_win(addr, WIN_MAINB);
  assign hit_lwb   = in_win(addr, WIN_LWB);
  assign hit_ocr   = in_win(addr, WIN_OCR_HI);

  always_comb begin
    sel = '0;
    if (hit_low) begin
      if (remap[RMP_OCRAM])      sel[SLV_OCRAM] = 1'b1;
      else if (remap[RMP_SDRAM]) sel[SLV_SDRAM] = 1'b1;
      else                       sel[SLV_BOOT]  = 1'b1;
    end else if (hit_sdram) begin
      sel[SLV_SDRAM] = 1'b1;
    end else if (hit_mainb) begin
      sel[SLV_MAINB] = remap[RMP_MAINB];
    end else if (hit_lwb) begin
      sel[SLV_LWB] = remap[RMP_LWB];
    end else if (hit_ocr) begin
      sel[SLV_OCRAM] = 1'b1;
    end
    derr = ~|sel;
  end

  // R2
  always_comb begin
    dec_onehot_chk: assert ($onehot0(sel));
  end

  // R3
  always_comb begin
    low_prio_chk: assert (!(hit_low && remap[RMP_OCRAM]) || sel[SLV_OCRAM]);
  end
endmodule

// File: rtl/remap_addr_decoder.sv
module remap_addr_decoder
  import remap_pkg::*;
#(
  parameter int NUM_MST = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_MST-1:0]         rmp_wr_en,
  input  logic [NUM_MST*REMAP_W-1:0] rmp_wr_data,
  input  logic [NUM_MST-1:0]         req_valid,
  input  logic [NUM_MST*ADDR_W-1:0]  req_addr,
  output logic [NUM_MST*NSLV-1:0]    slv_sel,
  output logic [NUM_MST-1:0]         dec_err,
  output logic [REMAP_W-1:0]         remap_val
);
  logic [REMAP_W-1:0] remap_q;

  remap_reg #(.NUM_MST(NUM_MST)) reg_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (rmp_wr_en),
    .wr_data (rmp_wr_data),
    .remap_q (remap_q)
  );

  assign remap_val = remap_q;

  for (genvar m = 0; m < NUM_MST; m++) begin : g_mst
    logic [ADDR_W-1:0] addr;
    logic [NSLV-1:0]   dsel, sel_d, sel_q;
    logic              derr_c, err_d, err_q;

    assign addr = req_addr[m*ADDR_W +: ADDR_W];

    remap_window_dec dec_i (
      .addr  (addr),
      .remap (remap_q),
      .sel   (dsel),
      .derr  (derr_c)
    );

    always_comb begin
      sel_d = req_valid[m] ? dsel : '0;
      err_d = req_valid[m] & derr_c;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sel_q <= '0;
        err_q <= 1'b0;
      end else begin
        sel_q <= sel_d;
        err_q <= err_d;
      end
    end

    assign slv_sel[m*NSLV +: NSLV] = sel_q;
    assign dec_err[m]              = err_q;

    // R8
    sel_err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err_q |-> sel_q == '0);

    // R12
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid[m] |=> (sel_q == '0) && !err_q);

    // R7
    lwb_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid[m] && in_win(addr, WIN_LWB) && !remap_q[RMP_LWB]) |=> err_q);

    // R2
    low_ocram_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid[m] && in_win(addr, WIN_LOW) && remap_q[RMP_OCRAM])
        |=> sel_q[SLV_OCRAM]);
  end
endmodule

// File: tb/remap_addr_decoder_tb.sv
`timescale 1ns/1ps
module remap_addr_decoder_tb_top;
  localparam int NM = 3;
  localparam int RW = 5;
  localparam int AW = 32;
  localparam int NS = 5;

  localparam logic [4:0] S_BOOT = 5'b00001;
  localparam logic [4:0] S_OCR  = 5'b00010;
  localparam logic [4:0] S_SDR  = 5'b00100;
  localparam logic [4:0] S_MAIN = 5'b01000;
  localparam logic [4:0] S_LW   = 5'b10000;
  localparam logic [4:0] S_NONE = 5'b00000;

  logic              clk = 1'b0;
  logic              rst_n;
  logic [NM-1:0]     rmp_wr_en;
  logic [NM*RW-1:0]  rmp_wr_data;
  logic [NM-1:0]     req_valid;
  logic [NM*AW-1:0]  req_addr;
  logic [NM*NS-1:0]  slv_sel;
  logic [NM-1:0]     dec_err;
  logic [RW-1:0]     remap_val;

  int total = 0;
  int bad   = 0;

  always #2.5 clk = ~clk;

  remap_addr_decoder #(.NUM_MST(NM)) dut_i (
    .clk(clk), .rst_n(rst_n), .rmp_wr_en(rmp_wr_en), .rmp_wr_data(rmp_wr_data),
    .req_valid(req_valid), .req_addr(req_addr), .slv_sel(slv_sel),
    .dec_err(dec_err), .remap_val(remap_val)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic write_remap(input int m, input logic [RW-1:0] v);
    @(negedge clk);
    rmp_wr_en[m] = 1'b1;
    rmp_wr_data[m*RW +: RW] = v;
    @(negedge clk);
    rmp_wr_en = '0;
    chk("R10 remap write", {27'b0, remap_val}, {27'b0, v});
  endtask

  task automatic probe(input string tag, input int m, input logic [31:0] a,
                       input logic [4:0] es, input logic ee);
    @(negedge clk);
    req_valid[m] = 1'b1;
    req_addr[m*AW +: AW] = a;
    @(negedge clk);
    chk(tag, {27'b0, slv_sel[m*NS +: NS]}, {27'b0, es});
    chk(tag, {31'b0, dec_err[m]}, {31'b0, ee});
    req_valid = '0;
  endtask

  task automatic t_reset();
    chk("R1 remap", {27'b0, remap_val}, 32'h0);
    chk("R1 sel", {17'b0, slv_sel}, 32'h0);
    chk("R1 err", {29'b0, dec_err}, 32'h0);
  endtask

  task automatic t_low_window();
    probe("R4 boot low", 0, 32'h0000_1234, S_BOOT, 1'b0);
    write_remap(0, 5'b00001);
    probe("R2 ocram low", 1, 32'h0000_FFFF, S_OCR, 1'b0);
    write_remap(1, 5'b00010);
    probe("R3 sdram low", 2, 32'h0000_0000, S_SDR, 1'b0);
    write_remap(2, 5'b00011);
    probe("R3 both prio", 0, 32'h0000_8000, S_OCR, 1'b0);
  endtask

  task automatic t_fixed();
    write_remap(0, 5'b00000);
    probe("R5 ocram high", 0, 32'hFFFF_0000, S_OCR, 1'b0);
    probe("R5 sdram body lo", 1, 32'h0001_0000, S_SDR, 1'b0);
    probe("R5 sdram body hi", 2, 32'hBFFF_FFFF, S_SDR, 1'b0);
    write_remap(0, 5'b00001);
    probe("R5 ocram high remap", 1, 32'hFFFF_FFFF, S_OCR, 1'b0);
  endtask

  task automatic t_bridges();
    write_remap(0, 5'b00000);
    probe("R6 main closed", 0, 32'hC000_0000, S_NONE, 1'b1);
    probe("R7 lw closed", 0, 32'hFF20_0000, S_NONE, 1'b1);
    write_remap(0, 5'b10000);
    probe("R6 main open", 0, 32'hFBFF_FFFF, S_MAIN, 1'b0);
    probe("R7 lw still closed", 1, 32'hFF3F_FFFF, S_NONE, 1'b1);
    write_remap(0, 5'b01000);
    probe("R7 lw open", 2, 32'hFF3F_FFFF, S_LW, 1'b0);
    probe("R6 main closed again", 2, 32'hC800_0000, S_NONE, 1'b1);
  endtask

  task automatic t_unmapped();
    write_remap(0, 5'b11011);
    probe("R8 gap after main", 0, 32'hFC00_0000, S_NONE, 1'b1);
    probe("R8 gap before lw", 1, 32'hFF1F_FFFF, S_NONE, 1'b1);
    probe("R8 gap after lw", 2, 32'hFF40_0000, S_NONE, 1'b1);
    probe("R8 gap before ocram", 0, 32'hFFFE_FFFF, S_NONE, 1'b1);
  endtask

  task automatic t_global();
    write_remap(2, 5'b00010);
    @(negedge clk);
    req_valid = '1;
    for (int m = 0; m < NM; m++) req_addr[m*AW +: AW] = 32'h0000_0100;
    @(negedge clk);
    for (int m = 0; m < NM; m++)
      chk("R9 shared map", {27'b0, slv_sel[m*NS +: NS]}, {27'b0, S_SDR});
    req_valid = '0;
  endtask

  task automatic t_timing();
    write_remap(0, 5'b00000);
    @(negedge clk);
    rmp_wr_en[0] = 1'b1;
    rmp_wr_data[RW-1:0] = 5'b00001;
    req_valid[1] = 1'b1;
    req_addr[AW +: AW] = 32'h0000_0010;
    @(negedge clk);
    rmp_wr_en = '0;
    chk("R10 same cycle old map", {27'b0, slv_sel[NS +: NS]}, {27'b0, S_BOOT});
    @(negedge clk);
    chk("R10 next cycle new map", {27'b0, slv_sel[NS +: NS]}, {27'b0, S_OCR});
    req_valid = '0;
    @(negedge clk);
    chk("R12 idle sel", {17'b0, slv_sel}, 32'h0);
    chk("R12 idle err", {29'b0, dec_err}, 32'h0);
    req_addr[0 +: AW] = 32'hFC00_0000;
    @(negedge clk);
    chk("R12 invalid no err", {31'b0, dec_err[0]}, 32'h0);
  endtask

  task automatic t_collide();
    @(negedge clk);
    rmp_wr_en = 3'b111;
    rmp_wr_data = {5'b11000, 5'b00010, 5'b00001};
    @(negedge clk);
    rmp_wr_en = '0;
    chk("R11 master0 wins", {27'b0, remap_val}, 32'h01);
    rmp_wr_en = 3'b110;
    rmp_wr_data = {5'b11000, 5'b10010, 5'b00000};
    @(negedge clk);
    rmp_wr_en = '0;
    chk("R11 master1 wins", {27'b0, remap_val}, 32'h12);
  endtask

  initial begin
    #50000;
    bad++;
    total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    rmp_wr_en = '0;
    rmp_wr_data = '0;
    req_valid = '0;
    req_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_low_window();
    t_fixed();
    t_bridges();
    t_unmapped();
    t_global();
    t_timing();
    t_collide();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule